// File: doc/BRIEF.md
# Multi-Input Edge Wakeup Controller

This block watches a group of port input pins and turns selected transitions on them into a single request line. The power-mode logic uses that line to leave its low-power states. The interrupt logic can use the same line as a set of edge-triggered external interrupts. Each pin has three controls: an enable bit, a polarity bit and a pending bit. The polarity bit chooses whether a rising or a falling transition counts. The pending bit records that a qualifying transition has been seen. The request line is high while any pin has both its pending bit and its enable bit set.

Each pin is first brought into the clock domain by a synchronizer chain. The synchronized level is then XORed with the pin's polarity bit. A small per-pin state machine follows the resulting polarized level. It has three states. ST_WARMUP is the state after reset. It takes the first valid level without raising an event (transition WARMUP to LOW or WARMUP to HIGH, taken on the arm signal). ST_LOW raises an event when the level becomes 1 (transition LOW to HIGH, the only transition that raises an event). ST_HIGH returns to ST_LOW when the level drops (transition HIGH to LOW, no event). A shared counter produces the arm signal once the synchronizer chain holds real samples.

Because the polarity bit is applied before the edge detector, flipping it can look like a transition. Software should therefore clear the enable bit, change the polarity, clear the pending bit and only then set the enable bit again. A pin that has just turned from output to input should get its polarity and a cleared pending bit before it is enabled.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset, the enable, polarity and pending registers all read 0 and `wake_o` is 0.
- R2: The enable register is selected by register code 0. Write op 0 loads the whole byte from `wr_data_i`. Op 1 sets bit `wr_bit_i`. Op 2 clears bit `wr_bit_i`. The result is visible on the read port in the cycle after the write edge.
- R3: The polarity register is selected by register code 1 and takes the same write ops as R2. In this register a bit of 1 selects a falling edge for its pin and 0 selects a rising edge.
- R4: Suppose a qualifying pin transition is first sampled at clock edge k. The pin's pending bit then reads 1 after edge k+2 and not before. This holds whether or not the pin is enabled.
- R5: `wake_o` is 1 exactly when some bit is set in both the pending register (register code 2) and the enable register. It follows register changes without any added delay.
- R6: For the pending register, software can only clear bits. A byte write (op 0) clears the bits written as 0 and leaves the bits written as 1 unchanged. Op 2 clears one bit. Op 1 has no effect.
- R7: If a pin's hardware event and a software clear of that same pending bit land on the same edge, the bit ends up set.
- R8: Changing a pin's polarity bit while its level stays fixed sets the pending bit if the polarized level rises. For example, setting the polarity bit to 1 while the pin is low sets the pin's pending bit on the edge after the write.
- R9: Pin levels present during reset, or during the first synchronizer cycles after reset, set no pending bits.
- R10: Writes with register code 3, or with op code 3, change no register. Reading with register code 3 returns 0.
- R11: A transition in the direction the polarity bit does not select sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous port pin levels |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_reg_i | input | 2 | Register code: 0 enable, 1 polarity, 2 pending, 3 none |
| wr_op_i | input | 2 | Write op: 0 byte, 1 set bit, 2 clear bit, 3 none |
| wr_bit_i | input | $clog2(NUM_PINS) | Bit index for ops 1 and 2 |
| wr_data_i | input | NUM_PINS | Byte data for op 0 |
| rd_reg_i | input | 2 | Register code to read |
| rd_data_o | output | NUM_PINS | Selected register value |
| wake_o | output | 1 | Wakeup / interrupt request |

## Verification
The bench builds the block with 8 pins and a 2-stage synchronizer. At that size a behavioural model can track every pin, and the three-cycle warmup window after reset is easy to reach and probe. A reference model follows every register and pin and is compared against the read port and the request line on every clock. Directed sequences then probe the pin-to-pending latency, spurious events from polarity changes, set-versus-clear collisions and reserved codes.

// File: rtl/edge_wake_pkg.sv
package edge_wake_pkg;

    typedef enum logic [1:0] {
        REG_EN   = 2'd0,
        REG_EDGE = 2'd1,
        REG_PEND = 2'd2,
        REG_NONE = 2'd3
    } wk_reg_e;

    typedef enum logic [1:0] {
        OP_BYTE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NONE = 2'd3
    } wk_op_e;

    typedef enum logic [1:0] {
        ST_WARMUP = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2
    } trk_state_e;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/edge_track.sv
module edge_track
    import edge_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic level_i,
    output logic event_o
);
    trk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WARMUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        event_o = 1'b0;
        unique case (state_q)
            ST_WARMUP: begin
                if (arm_i) state_d = level_i ? ST_HIGH : ST_LOW;
            end
            ST_LOW: begin
                if (level_i) begin
                    state_d = ST_HIGH;
                    event_o = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!level_i) state_d = ST_LOW;
            end
            default: state_d = ST_WARMUP;
        endcase
    end

    // R9: after arming the tracker never goes back to warmup
    assert_no_rewarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WARMUP) |=> (state_q != ST_WARMUP));
endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import edge_wake_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int BIT_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  wk_reg_e             wr_reg_i,
    input  wk_op_e              wr_op_i,
    input  logic [BIT_W-1:0]    wr_bit_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    input  logic [NUM_PINS-1:0] hw_set_i,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] sel_o,
    output logic [NUM_PINS-1:0] pend_o
);
    logic [NUM_PINS-1:0] en_q, sel_q, pend_q;
    logic [NUM_PINS-1:0] en_d, sel_d, pend_d, bit_mask;

    function automatic logic [NUM_PINS-1:0] ctl_update(
        input logic [NUM_PINS-1:0] cur, input wk_op_e op,
        input logic [NUM_PINS-1:0] mask, input logic [NUM_PINS-1:0] data);
        unique case (op)
            OP_BYTE: return data;
            OP_SET:  return cur | mask;
            OP_CLR:  return cur & ~mask;
            default: return cur;
        endcase
    endfunction

    always_comb begin
        bit_mask = NUM_PINS'(1) << wr_bit_i;
        en_d     = en_q;
        sel_d    = sel_q;
        pend_d   = pend_q;
        if (wr_en_i && wr_reg_i == REG_EN)   en_d  = ctl_update(en_q, wr_op_i, bit_mask, wr_data_i);
        if (wr_en_i && wr_reg_i == REG_EDGE) sel_d = ctl_update(sel_q, wr_op_i, bit_mask, wr_data_i);
        if (wr_en_i && wr_reg_i == REG_PEND) begin
            if (wr_op_i == OP_BYTE)     pend_d = pend_q & wr_data_i;
            else if (wr_op_i == OP_CLR) pend_d = pend_q & ~bit_mask;
        end
        pend_d = pend_d | hw_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            sel_q  <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= en_d;
            sel_q  <= sel_d;
            pend_q <= pend_d;
        end
    end

    assign en_o   = en_q;
    assign sel_o  = sel_q;
    assign pend_o = pend_q;

    assert_en_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_reg_i == REG_EN && wr_op_i == OP_BYTE) |=> (en_q == $past(wr_data_i)));

    assert_sw_cannot_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set_i == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set_i != '0) |=> ((pend_q & $past(hw_set_i)) == $past(hw_set_i)));

    assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_reg_i == REG_NONE || wr_op_i == OP_NONE))
            |=> ($stable(en_q) && $stable(sel_q)));
endmodule

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl
    import edge_wake_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int BIT_W      = $clog2(NUM_PINS),
    localparam int CNT_W      = $clog2(SYNC_STAGES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_reg_i,
    input  logic [1:0]          wr_op_i,
    input  logic [BIT_W-1:0]    wr_bit_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    input  logic [1:0]          rd_reg_i,
    output logic [NUM_PINS-1:0] rd_data_o,
    output logic                wake_o
);
    logic [NUM_PINS-1:0] pin_sync, polar, events;
    logic [NUM_PINS-1:0] en, sel, pend;
    logic [CNT_W-1:0]    warm_cnt_q;
    logic                arm;

    wake_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     warm_cnt_q <= '0;
        else if (!arm)  warm_cnt_q <= warm_cnt_q + 1'b1;
    end
    assign arm   = (warm_cnt_q == CNT_W'(SYNC_STAGES));
    assign polar = pin_sync ^ sel;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        edge_track u_track (
            .clk(clk), .rst_n(rst_n), .arm_i(arm),
            .level_i(polar[p]), .event_o(events[p])
        );
    end

    wake_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i),
        .wr_reg_i(wk_reg_e'(wr_reg_i)), .wr_op_i(wk_op_e'(wr_op_i)),
        .wr_bit_i(wr_bit_i), .wr_data_i(wr_data_i), .hw_set_i(events),
        .en_o(en), .sel_o(sel), .pend_o(pend)
    );

    always_comb begin
        unique case (wk_reg_e'(rd_reg_i))
            REG_EN:   rd_data_o = en;
            REG_EDGE: rd_data_o = sel;
            REG_PEND: rd_data_o = pend;
            default:  rd_data_o = '0;
        endcase
    end

    assign wake_o = |(pend & en);

    assert_warmup_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm) |-> (events == '0));

    assert_wake_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (en != '0 && pend != '0));

    assert_pend_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |=> ((pend & $past(events)) != '0));
endmodule

// File: tb/edge_wake_ctrl_bench.sv
module edge_wake_ctrl_bench;
    localparam int NP   = 8;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_reg = '0, wr_op = '0, rd_reg = 2'd2;
    logic [2:0] wr_bit = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       wake;

    int checks = 0, errors = 0;
    bit started = 0, done = 0;
    string cur_req = "R1";

    edge_wake_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(SYNC)) u_edge_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .wr_en_i(wr_en), .wr_reg_i(wr_reg),
        .wr_op_i(wr_op), .wr_bit_i(wr_bit), .wr_data_i(wr_data), .rd_reg_i(rd_reg),
        .rd_data_o(rd_data), .wake_o(wake)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    logic [7:0] m_sync [SYNC];
    logic [7:0] m_en, m_sel, m_pend, m_prev;
    int         m_cnt;
    bit         m_live;

    always @(posedge clk) begin : model
        logic [7:0] p, ev, mask, np;
        started <= 1;
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) m_sync[i] <= '0;
            m_en <= '0; m_sel <= '0; m_pend <= '0; m_prev <= '0;
            m_cnt <= 0; m_live <= 0;
        end else begin
            p  = m_sync[SYNC-1] ^ m_sel;
            ev = m_live ? (p & ~m_prev) : 8'h00;
            m_prev <= p;
            if (m_cnt == SYNC) m_live <= 1; else m_cnt <= m_cnt + 1;
            mask = 8'h01 << wr_bit;
            np = m_pend;
            if (wr_en && wr_op != 2'd3) begin
                if (wr_reg == 2'd0) m_en <= (wr_op == 0) ? wr_data : (wr_op == 1) ? (m_en | mask) : (m_en & ~mask);
                if (wr_reg == 2'd1) m_sel <= (wr_op == 0) ? wr_data : (wr_op == 1) ? (m_sel | mask) : (m_sel & ~mask);
                if (wr_reg == 2'd2) begin
                    if (wr_op == 0) np = m_pend & wr_data;
                    if (wr_op == 2) np = m_pend & ~mask;
                end
            end
            m_pend <= np | ev;
            m_sync[0] <= pin;
            for (int i = 1; i < SYNC; i++) m_sync[i] <= m_sync[i-1];
        end
    end

    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (started && !done) begin
            exp_rd = (rd_reg == 0) ? m_en : (rd_reg == 1) ? m_sel : (rd_reg == 2) ? m_pend : 8'h00;
            checks++;
            if (rd_data !== exp_rd) begin
                errors++;
                $display("FAIL %s rd_data reg %0d actual %h expected %h", cur_req, rd_reg, rd_data, exp_rd);
            end
            checks++;
            if (wake !== |(m_pend & m_en)) begin
                errors++;
                $display("FAIL %s wake actual %b expected %b", cur_req, wake, |(m_pend & m_en));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] r, input logic [1:0] op, input logic [2:0] b, input logic [7:0] d);
        wr_en = 1; wr_reg = r; wr_op = op; wr_bit = b; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] r, input logic [7:0] exp);
        rd_reg = r; #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s reg %0d actual %h expected %h", req, r, rd_data, exp);
        end
        rd_reg = 2'd2;
    endtask

    task automatic chk_wake(input string req, input logic exp);
        checks++;
        if (wake !== exp) begin
            errors++;
            $display("FAIL %s wake actual %b expected %b", req, wake, exp);
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk_reg("R1", 2'd0, 8'h00); chk_reg("R1", 2'd1, 8'h00); chk_reg("R1", 2'd2, 8'h00);
        chk_wake("R1", 1'b0);
        rst_n = 1;
        repeat (5) tick();

        cur_req = "R2";
        wr(2'd0, 2'd0, 3'd0, 8'hA5);
        chk_reg("R2", 2'd0, 8'hA5);
        wr(2'd0, 2'd1, 3'd1, 8'h00);
        wr(2'd0, 2'd2, 3'd0, 8'h00);
        chk_reg("R2", 2'd0, 8'hA6);

        cur_req = "R8";
        wr(2'd1, 2'd0, 3'd0, 8'h0F);
        chk_reg("R3", 2'd1, 8'h0F);
        chk_reg("R8", 2'd2, 8'h00);
        tick();
        chk_reg("R8", 2'd2, 8'h0F);

        cur_req = "R6";
        wr(2'd2, 2'd0, 3'd0, 8'h00);
        chk_reg("R6", 2'd2, 8'h00);

        cur_req = "R4";
        pin = 8'h30;
        tick(); tick();
        chk_reg("R4", 2'd2, 8'h00);
        tick();
        chk_reg("R4", 2'd2, 8'h30);

        cur_req = "R11";
        pin = 8'h31;
        repeat (4) tick();
        chk_reg("R11", 2'd2, 8'h30);
        pin = 8'h30;
        repeat (4) tick();
        chk_reg("R3", 2'd2, 8'h31);

        cur_req = "R5";
        chk_wake("R5", 1'b1);
        wr(2'd2, 2'd2, 3'd5, 8'h00);
        chk_reg("R6", 2'd2, 8'h11);
        chk_wake("R5", 1'b0);

        cur_req = "R7";
        pin = 8'h70;
        tick(); tick();
        wr(2'd2, 2'd2, 3'd6, 8'h00);
        chk_reg("R7", 2'd2, 8'h51);

        cur_req = "R6";
        wr(2'd2, 2'd1, 3'd1, 8'h00);
        chk_reg("R6", 2'd2, 8'h51);
        wr(2'd2, 2'd0, 3'd0, 8'hF0);
        chk_reg("R6", 2'd2, 8'h50);

        cur_req = "R10";
        wr(2'd3, 2'd0, 3'd0, 8'hFF);
        wr(2'd0, 2'd3, 3'd0, 8'hFF);
        chk_reg("R10", 2'd0, 8'hA6);
        chk_reg("R10", 2'd1, 8'h0F);
        chk_reg("R10", 2'd3, 8'h00);

        cur_req = "R9";
        rst_n = 0; pin = 8'hFF;
        repeat (3) tick();
        rst_n = 1;
        repeat (10) tick();
        chk_reg("R9", 2'd2, 8'h00);

        cur_req = "R4";
        wr(2'd0, 2'd0, 3'd0, 8'h5A);
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) pin = pin ^ (8'h01 << $urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) begin
                wr_en = 1; wr_reg = 2'($urandom_range(0, 3)); wr_op = 2'($urandom_range(0, 3));
                wr_bit = 3'($urandom_range(0, 7)); wr_data = 8'($urandom);
            end else wr_en = 0;
            rd_reg = 2'($urandom_range(0, 3));
            tick();
        end
        wr_en = 0;
        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule